// File: doc/BRIEF.md
# Seven-Pin General-Purpose I/O Port

This block is a small bidirectional general-purpose I/O port of seven pins, numbered 0 to 6, controlled over a simple byte-wide register bus. A direction bit per pin chooses whether the pin drives (1) or listens (0). An output data register supplies the value that is driven on pins set as outputs. A pin read returns the pin levels after a two-flop synchronizer.

The direction register cannot be read back. It sits at the same bus address as the pin read, so a read there returns the live synchronized pin levels, never the direction bits. Two resets are modelled. The system reset clears both the direction register and the output data register. The watchdog reset leaves both registers untouched and clears only the synchronizer flops.

Address map: address 0 is a write to the direction register and a read of the pins. Address 1 is the output data register, which can be read and written. Addresses 2 and 3 are unused. Bit 7 of every register is reserved. It reads as 0, and writes to it are ignored.

Top module: `gpio7_port`

## Requirements
- R1: After a system reset, every pin_oe bit is 0 and a read of address 1 returns 0x00.
- R2: A write strobe at address 0 loads bus_wdata[6:0] into the direction bits on that clock edge. pin_oe[n] then equals direction bit n, where 1 means output.
- R3: A read at address 0 returns the synchronized pin levels in bits 6:0 and 0 in bit 7. The direction bits never appear in this value.
- R4: A write strobe at address 1 loads bus_wdata[6:0] into the output data register. pin_out equals that register, and a read of address 1 returns it with bit 7 at 0.
- R5: Bit 7 of a write is ignored at both addresses. Reads at every address return 0 in bit 7.
- R6: Asserting the watchdog reset changes neither the direction bits nor the output data register.
- R7: A change on pin_in is first visible on a pin read after exactly two rising clock edges.
- R8: Writes to addresses 2 and 3, and any bus cycle with bus_we low, leave pin_oe and pin_out unchanged. Reads of addresses 2 and 3 return 0x00.
- R9: bus_rdata is 0x00 whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| wdt_rst_n | input | 1 | Watchdog internal reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| pin_in | input | 7 | Pin levels from the pads |
| pin_out | output | 7 | Values to drive on the pads |
| pin_oe | output | 7 | Per-pin output enable |

## Verification
Direction and output data are written with alternating, walking and all-ones patterns, each with bit 7 set. This shows whether bit 7 leaks into a register and whether the two registers are swapped or aliased. Pin reads are made with the direction register holding a pattern different from the pin pattern, so a read that returns direction bits is caught. A pin step is read one edge and two edges after the change, which pins the synchronizer depth at exactly two. A watchdog pulse between known register contents separates the two reset domains.

// File: rtl/gpio7_pkg.sv
package gpio7_pkg;
  localparam int PORT_W  = 7;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR_PIN = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ODR     = 2'd1;

  // Place a port-wide value on the byte bus with the reserved bits at 0.
  function automatic logic [DATA_W-1:0] to_bus(input logic [PORT_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[PORT_W-1:0] = v;
    return r;
  endfunction

  // Take the port-wide field of a bus byte; reserved bits are dropped.
  function automatic logic [PORT_W-1:0] from_bus(input logic [DATA_W-1:0] b);
    return b[PORT_W-1:0];
  endfunction
endpackage

// File: rtl/gpio7_sync.sv
module gpio7_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

  // Cycles since reset, saturating, so the latency check never looks before reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (q_sync == $past(d_async, 2))); // R7
    end
  endgenerate
endmodule

// File: rtl/gpio7_regs.sv
module gpio7_regs
  import gpio7_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         sys_rst_n,
  input  logic         wr_dir,
  input  logic         wr_odr,
  input  logic [W-1:0] wfield,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] odr_q
);
  // Only the system reset touches these registers; the watchdog reset is not wired in.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) dir_q <= '0;
    else if (wr_dir) dir_q <= wfield;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) odr_q <= '0;
    else if (wr_odr) odr_q <= wfield;
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wr_dir |=> (dir_q == $past(wfield))); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !wr_dir |=> $stable(dir_q)); // R6
  AST_ODR_LOAD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wr_odr |=> (odr_q == $past(wfield))); // R4
  AST_ODR_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !wr_odr |=> $stable(odr_q)); // R8
endmodule

// File: rtl/gpio7_rdmux.sv
module gpio7_rdmux
  import gpio7_pkg::*;
(
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] pins_sync,
  input  logic [PORT_W-1:0] odr_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (re) begin
      unique case (addr)
        ADDR_DIR_PIN: rdata = to_bus(pins_sync);
        ADDR_ODR:     rdata = to_bus(odr_q);
        default:      rdata = '0;
      endcase
    end
  end

  always_comb begin
    AST_RSVD_READ_ZERO: assert (rdata[DATA_W-1] == 1'b0); // R5
    AST_IDLE_READ_ZERO: assert (re || rdata == '0); // R9
  end
endmodule

// File: rtl/gpio7_port.sv
module gpio7_port
  import gpio7_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              wdt_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  // Named bus events
  logic wr_dir_ev, wr_odr_ev;
  assign wr_dir_ev = bus_we && (bus_addr == ADDR_DIR_PIN);
  assign wr_odr_ev = bus_we && (bus_addr == ADDR_ODR);

  // The synchronizer is cleared by either reset.
  logic sync_rst_n;
  assign sync_rst_n = sys_rst_n & wdt_rst_n;

  logic [PORT_W-1:0] pins_sync, dir_q, odr_q;

  gpio7_sync #(.WIDTH(PORT_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (sync_rst_n),
    .d_async (pin_in),
    .q_sync  (pins_sync)
  );

  gpio7_regs #(.W(PORT_W)) u_regs (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .wr_dir    (wr_dir_ev),
    .wr_odr    (wr_odr_ev),
    .wfield    (from_bus(bus_wdata)),
    .dir_q     (dir_q),
    .odr_q     (odr_q)
  );

  gpio7_rdmux u_rdmux (
    .re        (bus_re),
    .addr      (bus_addr),
    .pins_sync (pins_sync),
    .odr_q     (odr_q),
    .rdata     (bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = odr_q;

  AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_we && bus_wdata[DATA_W-1] && bus_addr == ADDR_ODR) |=>
      (bus_rdata[DATA_W-1] == 1'b0)); // R5
  AST_WDT_KEEPS_OE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!wdt_rst_n && !bus_we) |=> $stable(pin_oe)); // R6
  AST_WDT_KEEPS_OUT: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!wdt_rst_n && !bus_we) |=> $stable(pin_out)); // R6
  AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (bus_we && bus_addr[1]) |=> ($stable(pin_oe) && $stable(pin_out))); // R8
endmodule

// File: tb/test_gpio7_port.sv
module test_gpio7_port;
  logic       clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       wdt_rst_n = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in = '0;
  logic [6:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpio7_port i_gpio7_port (
    .clk(clk), .sys_rst_n(sys_rst_n), .wdt_rst_n(wdt_rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Scoreboard of expected read data
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Monitor: one sample per read cycle, at the falling edge
  always @(negedge clk) begin
    if (bus_re) begin
      if (exp_q.size() == 0) check("scoreboard-empty", bus_rdata, 8'hxx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_idle();
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_re = 1'b0; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
  endtask

  task automatic set_pins(input logic [6:0] v);
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0; pin_in = v;
  endtask

  task automatic check_outs(input string req, input logic [6:0] oe, input logic [6:0] o);
    @(negedge clk);
    check({req, " oe"}, {1'b0, pin_oe}, {1'b0, oe});
    check({req, " out"}, {1'b0, pin_out}, {1'b0, o});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 sys_rst_n = 1'b1;
    // R1 reset state
    check_outs("R1", 7'h00, 7'h00);
    bus_read(2'd1, 8'h00, "R1 odr after reset");
    // R9 idle read
    bus_idle();
    @(negedge clk); check("R9 idle rdata", bus_rdata, 8'h00);

    // R2 / R5 direction writes, bit 7 set
    bus_write(2'd0, 8'hAA); bus_idle();
    check_outs("R2 dir AA", 7'h2A, 7'h00);
    bus_write(2'd0, 8'hD5); bus_idle();
    check_outs("R2 R5 dir D5", 7'h55, 7'h00);

    // R4 / R5 output data
    bus_write(2'd1, 8'hFF); bus_idle();
    check_outs("R4 odr FF", 7'h55, 7'h7F);
    bus_read(2'd1, 8'h7F, "R4 R5 odr readback");
    bus_write(2'd1, 8'h13);
    bus_read(2'd1, 8'h13, "R4 odr 13");

    // R3 pin read differs from direction bits
    set_pins(7'h0F); bus_idle(); bus_idle();
    bus_read(2'd0, 8'h0F, "R3 pins 0F");
    set_pins(7'h7F); bus_idle(); bus_idle();
    bus_read(2'd0, 8'h7F, "R3 R5 pins 7F");

    // R7 synchronizer depth
    set_pins(7'h21);
    bus_read(2'd0, 8'h7F, "R7 one edge old");
    bus_read(2'd0, 8'h21, "R7 two edges new");

    // R8 unused addresses and writes without strobe
    bus_write(2'd2, 8'h00); bus_write(2'd3, 8'h7F); bus_idle();
    check_outs("R8 unused write", 7'h55, 7'h13);
    bus_read(2'd2, 8'h00, "R8 read addr2");
    bus_read(2'd3, 8'h00, "R8 read addr3");
    @(posedge clk); #1; bus_re = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h7F;
    bus_idle();
    check_outs("R8 no strobe", 7'h55, 7'h13);

    // R6 watchdog reset keeps registers
    @(posedge clk); #1; wdt_rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 wdt_rst_n = 1'b1;
    check_outs("R6 after wdt", 7'h55, 7'h13);
    bus_read(2'd1, 8'h13, "R6 odr after wdt");

    // R1 system reset again clears both
    @(posedge clk); #1; bus_re = 1'b0; sys_rst_n = 1'b0;
    @(posedge clk); #1; sys_rst_n = 1'b1;
    check_outs("R1 second reset", 7'h00, 7'h00);
    bus_read(2'd1, 8'h00, "R1 odr second reset");
    bus_idle(); bus_idle();
    if (exp_q.size() != 0) check("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule